// File: doc/BRIEF.md
# I2C Transmit Abort Cause Register

This block records why an I2C controller gave up on a transfer. The master and slave engines report each failure as a one-cycle pulse on its own line. The block latches every pulse into a sticky cause bit and presents all of them as one 32-bit read-only status word. Software reads that word at offset 0x80 of the controller's register space. A combined abort interrupt is raised whenever any cause bit is set.

Software clears the causes by reading either of two clear registers: the abort-only clear or the clear-all-interrupts register. The START-byte-without-restart cause (bit 9) behaves differently. While its configuration fault is still present, a clear removes the bit for exactly one cycle and the bit then comes back. A 9-bit field in the upper bits counts the TX FIFO commands that were flushed because of an abort. That count is reset only by disabling the controller.

The block is purely control and status. Every pin is a plain level or a one-cycle strobe, so no valid/ready flow control or back-pressure is involved. The status word and the interrupt are registered outputs. An event or clear seen at one rising edge is visible right after that edge.

Top module: `i2c_abort_status`

## Requirements
- R1: After reset, the status word reads 0x00000000 and the interrupt output is 0.
- R2: An event pulse on line i (bits 0 to 8, 10, 11, 12, 13, 15, 16) sets status bit i at the next edge, and the bit stays set until a clear.
  - bit 0: 7-bit address not acknowledged
  - bit 1: first 10-bit address byte not acknowledged
  - bit 2: second 10-bit address byte not acknowledged
  - bit 3: data byte not acknowledged
  - bit 4: general call not acknowledged
  - bit 5: general call followed by a read
  - bit 6: high-speed master code acknowledged
  - bit 7: START byte acknowledged
  - bit 8: high-speed transfer with restart disabled
  - bit 10: 10-bit read with restart disabled
  - bit 11: master operation while master mode is off
  - bit 12: arbitration lost
  - bit 13: slave flushed stale TX data
  - bit 15: slave read command written as data
  - bit 16: user-requested abort
- R3: A one-cycle read strobe on either clear input (clr_abort_rd or clr_all_rd) clears every cause bit whose line is not pulsing in that cycle. For bit 9, R6 and R7 also apply.
- R4: If an event pulse and a clear strobe occur in the same cycle, the event wins and its bit reads 1 afterwards.
- R5: A pulse on line 14 (slave lost the bus while transmitting) sets both bit 14 and bit 12 at the same edge. A pulse on line 12 alone sets bit 12 and leaves bit 14 at 0.
- R6: A pulse on line 9 sets bit 9 (START byte attempted with restart disabled). The fault counts as present when restart_en=0, tar_special=1 and tar_gc_or_start=1. With the fault absent, a clear resets bit 9 like any other bit.
- R7: A clear of a set bit 9 while the fault is present makes bit 9 read 0 for exactly one cycle and 1 in the cycle after.
- R8: Bits 31:23 count flush_pulse strobes while ctrl_enable=1. The count is forced to 0 while ctrl_enable=0, and the clear strobes do not affect it.
- R9: The flush count saturates at 511 and does not wrap.
- R10: Bits 22:17 always read 0.
- R11: abort_irq equals the OR of status bits 16:0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort_pulse | input | 17 | One-cycle abort event per cause line; index equals the status bit |
| flush_pulse | input | 1 | One TX FIFO command flushed by an abort |
| restart_en | input | 1 | Restart-enable control bit |
| tar_special | input | 1 | Target-address special-command bit |
| tar_gc_or_start | input | 1 | Target-address general-call/START-byte select bit |
| ctrl_enable | input | 1 | Controller enable; 0 clears the flush count |
| clr_abort_rd | input | 1 | Read strobe of the abort clear register |
| clr_all_rd | input | 1 | Read strobe of the clear-all-interrupts register |
| status_word | output | 32 | Abort cause status word |
| abort_irq | output | 1 | Combined abort interrupt |

## Verification
Directed sequences cover several cases:
- Single events, which confirm that each cause is held.
- An event colliding with a clear, which tells event priority apart from clear priority.
- The slave-arbitration pulse against a lone arbitration pulse, which shows whether bit 12 is paired correctly.
- Clears of bit 9 with the fault held and with it removed, which separate the one-cycle dip from a normal clear.

A run of more than 511 flushes, followed by clears and a controller disable, tells saturation apart from wrap. It also shows that the count is reset only by the disable. Random cycles then mix sparse events, clear strobes, fault-bit changes and enable drops, and every output field is compared with a bench model each cycle. This exposes interactions that the directed cases leave out.

// File: rtl/i2c_abrt_pkg.sv
package i2c_abrt_pkg;
  localparam int CAUSE_W  = 17;
  localparam int CNT_W    = 9;
  localparam int STAT_W   = 32;
  localparam int RSV_W    = STAT_W - CNT_W - CAUSE_W;
  localparam int B_ARB    = 12;
  localparam int B_SARB   = 14;
  localparam int B_SBYTE  = 9;
endpackage

// File: rtl/abrt_sbyte_guard.sv
module abrt_sbyte_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic restart_en,
  input  logic tar_special,
  input  logic tar_gc_or_start,
  output logic flag
);
  logic fault;
  logic pend;

  // The fault persists while restart is off and START-byte mode is selected.
  assign fault = !restart_en && tar_special && tar_gc_or_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      pend <= 1'b0;
    end else begin
      pend <= clr && fault && flag && !evt;
      flag <= evt || pend || (flag && !clr);
    end
  end
endmodule

// File: rtl/abrt_cause_bank.sv
module abrt_cause_bank #(
  parameter int W    = 17,
  parameter int SKIP = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  input  logic         restart_en,
  input  logic         tar_special,
  input  logic         tar_gc_or_start,
  output logic [W-1:0] cause_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == SKIP) begin : g_guard
      abrt_sbyte_guard u_guard (
        .clk             (clk),
        .rst_n           (rst_n),
        .evt             (set_vec[i]),
        .clr             (clr),
        .restart_en      (restart_en),
        .tar_special     (tar_special),
        .tar_gc_or_start (tar_gc_or_start),
        .flag            (cause_q[i])
      );
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cause_q[i] <= 1'b0;
        else if (set_vec[i]) cause_q[i] <= 1'b1;
        else if (clr)        cause_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/abrt_flush_count.sv
module abrt_flush_count #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!enable)                cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_abort_status.sv
module i2c_abort_status
  import i2c_abrt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] abort_pulse,
  input  logic               flush_pulse,
  input  logic               restart_en,
  input  logic               tar_special,
  input  logic               tar_gc_or_start,
  input  logic               ctrl_enable,
  input  logic               clr_abort_rd,
  input  logic               clr_all_rd,
  output logic [STAT_W-1:0]  status_word,
  output logic               abort_irq
);
  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] cause_q;
  logic [CNT_W-1:0]   flush_cnt;
  logic               clr;

  assign clr = clr_abort_rd || clr_all_rd;

  // A slave-side bus loss also reports a general arbitration loss.
  always_comb begin
    set_vec         = abort_pulse;
    set_vec[B_ARB]  = abort_pulse[B_ARB] || abort_pulse[B_SARB];
  end

  abrt_cause_bank #(.W(CAUSE_W), .SKIP(B_SBYTE)) u_bank (
    .clk             (clk),
    .rst_n           (rst_n),
    .set_vec         (set_vec),
    .clr             (clr),
    .restart_en      (restart_en),
    .tar_special     (tar_special),
    .tar_gc_or_start (tar_gc_or_start),
    .cause_q         (cause_q)
  );

  abrt_flush_count #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ctrl_enable),
    .inc    (flush_pulse),
    .cnt    (flush_cnt)
  );

  assign status_word = {flush_cnt, {RSV_W{1'b0}}, cause_q};
  assign abort_irq   = |cause_q;
endmodule

// File: rtl/i2c_abort_status_chk.sv
module i2c_abort_status_chk
  import i2c_abrt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CAUSE_W-1:0] abort_pulse,
  input logic               flush_pulse,
  input logic               restart_en,
  input logic               tar_special,
  input logic               tar_gc_or_start,
  input logic               ctrl_enable,
  input logic               clr_abort_rd,
  input logic               clr_all_rd,
  input logic [STAT_W-1:0]  status_word,
  input logic               abort_irq
);
  logic clr_any;
  logic fault_now;
  assign clr_any   = clr_abort_rd || clr_all_rd;
  assign fault_now = !restart_en && tar_special && tar_gc_or_start;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse[3] |=> status_word[3]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && !abort_pulse[0]) |=> !status_word[0]);

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse[16] && clr_any) |=> status_word[16]);

  p_arb_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse[B_SARB] |=> (status_word[B_SARB] && status_word[B_ARB]));

  p_dip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && status_word[B_SBYTE] && fault_now && !abort_pulse[B_SBYTE])
      |=> (!status_word[B_SBYTE] ##1 status_word[B_SBYTE]));

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_enable |=> (status_word[STAT_W-1 -: CNT_W] == '0));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_enable && status_word[STAT_W-1 -: CNT_W] == '1)
      |=> (status_word[STAT_W-1 -: CNT_W] == '1));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[STAT_W-CNT_W-1:CAUSE_W] == '0);

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq == (status_word[CAUSE_W-1:0] != '0));
endmodule

bind i2c_abort_status i2c_abort_status_chk u_chk (.*);

// File: tb/i2c_abort_status_tb.sv
module i2c_abort_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] abort_pulse = '0;
  logic        flush_pulse = 1'b0;
  logic        restart_en = 1'b1;
  logic        tar_special = 1'b0;
  logic        tar_gc_or_start = 1'b0;
  logic        ctrl_enable = 1'b0;
  logic        clr_abort_rd = 1'b0;
  logic        clr_all_rd = 1'b0;
  logic [31:0] status_word;
  logic        abort_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [16:0] m_cause = '0;
  logic        m_pend = 1'b0;
  logic [8:0]  m_cnt = '0;

  always #2 clk = ~clk;

  i2c_abort_status u_dut (
    .clk(clk), .rst_n(rst_n), .abort_pulse(abort_pulse), .flush_pulse(flush_pulse),
    .restart_en(restart_en), .tar_special(tar_special), .tar_gc_or_start(tar_gc_or_start),
    .ctrl_enable(ctrl_enable), .clr_abort_rd(clr_abort_rd), .clr_all_rd(clr_all_rd),
    .status_word(status_word), .abort_irq(abort_irq)
  );

  function automatic logic [31:0] exp_word();
    return {m_cnt, 6'b0, m_cause};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Model next state from requirements R2..R9 using the inputs of the cycle.
  task automatic model_step();
    logic        clr;
    logic        fault;
    logic [16:0] setv;
    logic [16:0] nxt;
    logic        npend;
    clr   = clr_abort_rd | clr_all_rd;
    fault = !restart_en && tar_special && tar_gc_or_start;
    setv  = abort_pulse;
    if (abort_pulse[14]) setv[12] = 1'b1;
    for (int i = 0; i < 17; i++) nxt[i] = setv[i] | (m_cause[i] & ~clr);
    npend  = clr && fault && m_cause[9] && !abort_pulse[9];
    nxt[9] = abort_pulse[9] | m_pend | (m_cause[9] & ~clr);
    m_cause = nxt;
    m_pend  = npend;
    if (!ctrl_enable)                    m_cnt = '0;
    else if (flush_pulse && m_cnt != '1) m_cnt = m_cnt + 1'b1;
  endtask

  // One clock: inputs already driven; sample 1 ns after the edge.
  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    check("R2/R3 causes", {15'b0, status_word[16:10], 1'b0, status_word[8:0]},
          {15'b0, m_cause[16:10], 1'b0, m_cause[8:0]});
    check("R6 bit9", {31'b0, status_word[9]}, {31'b0, m_cause[9]});
    check("R8 count", {23'b0, status_word[31:23]}, {23'b0, m_cnt});
    check("R10 reserved", {26'b0, status_word[22:17]}, 32'd0);
    check("R11 irq", {31'b0, abort_irq}, {31'b0, |m_cause});
  endtask

  task automatic idle_inputs();
    abort_pulse = '0; flush_pulse = 1'b0; clr_abort_rd = 1'b0; clr_all_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", status_word, 32'd0);
    check("R1 reset irq", {31'b0, abort_irq}, 32'd0);
    rst_n = 1'b1;
    ctrl_enable = 1'b1;
    tick();

    // R2: single event held
    abort_pulse = 17'h00008; tick(); idle_inputs(); tick();
    check("R2 bit3 held", {31'b0, status_word[3]}, 32'd1);

    // R5: slave bus loss sets 14 and 12 together
    clr_all_rd = 1'b1; tick(); idle_inputs();
    abort_pulse[14] = 1'b1; tick(); idle_inputs();
    check("R5 pair", {30'b0, status_word[14], status_word[12]}, 32'd3);
    clr_abort_rd = 1'b1; tick(); idle_inputs();
    abort_pulse[12] = 1'b1; tick(); idle_inputs();
    check("R5 lone", {30'b0, status_word[14], status_word[12]}, 32'd1);

    // R4: event and clear in the same cycle
    abort_pulse[0] = 1'b1; clr_all_rd = 1'b1; tick(); idle_inputs();
    check("R4 event wins", {15'b0, status_word[16:0]}, 32'd1);

    // R3: clear via abort clear register
    clr_abort_rd = 1'b1; tick(); idle_inputs();
    check("R3 cleared", status_word & 32'h1FFFF, 32'd0);

    // R7: clear while fault present dips for one cycle
    restart_en = 1'b0; tar_special = 1'b1; tar_gc_or_start = 1'b1;
    abort_pulse[9] = 1'b1; tick(); idle_inputs();
    clr_all_rd = 1'b1; tick(); idle_inputs();
    check("R7 dip", {31'b0, status_word[9]}, 32'd0);
    tick();
    check("R7 back", {31'b0, status_word[9]}, 32'd1);

    // R6: fault removed, clear is ordinary
    restart_en = 1'b1;
    clr_abort_rd = 1'b1; tick(); idle_inputs();
    check("R6 cleared", {31'b0, status_word[9]}, 32'd0);
    tick();
    check("R6 stays", {31'b0, status_word[9]}, 32'd0);

    // R8/R9: flush counting and saturation
    for (int k = 0; k < 520; k++) begin
      flush_pulse = 1'b1; tick();
    end
    idle_inputs();
    check("R9 saturate", {23'b0, status_word[31:23]}, 32'd511);
    clr_all_rd = 1'b1; clr_abort_rd = 1'b1; tick(); idle_inputs();
    check("R8 clear ignored", {23'b0, status_word[31:23]}, 32'd511);
    ctrl_enable = 1'b0; tick();
    check("R8 disable", {23'b0, status_word[31:23]}, 32'd0);
    ctrl_enable = 1'b1;

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 17; b++) abort_pulse[b] = ($urandom % 24) == 0;
      flush_pulse     = ($urandom % 3) == 0;
      clr_abort_rd    = ($urandom % 9) == 0;
      clr_all_rd      = ($urandom % 11) == 0;
      if (($urandom % 16) == 0) restart_en      = $urandom % 2;
      if (($urandom % 16) == 0) tar_special     = $urandom % 2;
      if (($urandom % 16) == 0) tar_gc_or_start = $urandom % 2;
      ctrl_enable     = ($urandom % 64) != 0;
      tick();
    end
    idle_inputs();
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule